// File: doc/BRIEF.md
# Decoded Micro-op Line Cache with Fill Packer

This block keeps already-decoded micro-ops for 32-byte aligned code windows, so that the fetch path can skip decoding when it returns to code it has seen before. A fill stream delivers the decoded instructions of one window in program order. Each instruction carries its byte address, the offset that follows it, its micro-op count, up to six micro-op payloads and a flag for an unconditional or predicted-taken branch. The packer groups the micro-ops into six-slot lines. It never splits the micro-ops of one instruction across two lines. It closes a line when the line is full, after a taken branch, and at the end of the window. All lines of a window go into the set selected by the window address.

A window that needs more than three lines, or that contains an instruction with more than six micro-ops, is not cached. Any of its lines already written are withdrawn, and a one-cycle reject pulse tells the fetch path to use the legacy decoders. The lookup port reads one line per cycle. It takes the virtual fetch address directly, with no translation. It returns the line whose first instruction starts at that byte, together with its slot valid bits, the fetch offset that follows it, its taken-branch flag and its position within the window. A translation flush clears every line. An instruction-cache eviction of a 64-byte line clears the two windows that line covers.

Top module: `uop_line_packer`

## Requirements
- R1: A lookup presented in one cycle is answered in the next cycle. It hits only on a valid line whose tag (address bits 31:10) matches, whose set (bits 9:5) matches and whose first-instruction offset (bits 4:0) equals the lookup offset. It returns the six payload slots (slot k in bits 16k+15:16k), a valid mask with bit k for slot k, the next fetch offset and the line's sequence number 0, 1 or 2 within its window.
- R2: All micro-ops of an instruction land in one line in consecutive slots after those already in it. If they do not fit in the open line, that line is written as it stands and a new line starts with the instruction.
- R3: A line is written and closed once it holds six micro-ops, after an instruction flagged as a taken branch (its taken flag then reads 1), or at the last instruction of the window. The next instruction starts a new line.
- R4: A window that would need a fourth line is rejected. Its lines already written become invalid, and fill_reject is high for exactly the one cycle after the offending instruction.
- R5: An instruction with more than six micro-ops rejects its window in the same way. Every later instruction of that window is ignored until the next first instruction.
- R6: Every line of a window is placed in the set given by address bits 9:5. Victim ways in a set are taken in round-robin order from way 0, so the ninth window filled into one set replaces the first.
- R7: inv_all invalidates every line. A lookup in any later cycle misses.
- R8: An eviction naming a 64-byte line (address bits 31:6) invalidates the lines of both 32-byte windows inside it, and no other lines.
- R9: After reset no line is valid, every lookup misses and fill_reject is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fill_valid | input | 1 | A decoded instruction is presented |
| fill_first | input | 1 | Instruction is the first of a new window |
| fill_last | input | 1 | Instruction is the last of its window |
| fill_addr | input | 32 | Virtual byte address of the instruction |
| fill_next_off | input | 6 | Window offset following the instruction (0..32) |
| fill_nuops | input | 4 | Micro-op count of the instruction |
| fill_taken | input | 1 | Instruction is an unconditional or predicted-taken branch |
| fill_uops | input | 96 | Micro-op payloads, slot k in bits 16k+15:16k |
| fill_reject | output | 1 | One-cycle pulse: current window will not be cached |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | 32 | Virtual fetch address for lookup |
| lk_hit | output | 1 | Lookup found a line |
| lk_slot_vld | output | 6 | Valid bit per returned slot |
| lk_uops | output | 96 | Returned micro-op payloads |
| lk_next_off | output | 6 | Fetch offset following the returned line |
| lk_taken | output | 1 | Returned line ended on a taken branch |
| lk_seq | output | 2 | Line position within its window |
| inv_all | input | 1 | Translation flush: invalidate all lines |
| evict_valid | input | 1 | Instruction-cache eviction strobe |
| evict_line | input | 26 | Address bits 31:6 of the evicted 64-byte line |

## Verification
The assertions assume that a window's instructions arrive contiguously, opened by fill_first and closed by fill_last. They also assume every instruction reports at least one micro-op and the payload slots above its count are zero. The bench drives each window as an uninterrupted burst with nonzero counts and zeroed unused slots. The one count above six it sends is deliberate and is expected to be rejected. It issues lookups only while no fill is in flight, so line contents never change between request and answer.

// File: rtl/uop_line_packer.sv
module uop_line_packer #(
  parameter int VA_W      = 32,
  parameter int SETS      = 32,
  parameter int WAYS      = 8,
  parameter int SLOTS     = 6,
  parameter int UOP_W     = 16,
  parameter int WIN_BYTES = 32,
  parameter int MAX_LINES = 3,
  localparam int OFF_W  = $clog2(WIN_BYTES),
  localparam int SET_W  = $clog2(SETS),
  localparam int WAY_W  = $clog2(WAYS),
  localparam int TAG_W  = VA_W - OFF_W - SET_W,
  localparam int CNT_W  = $clog2(SLOTS + 1),
  localparam int NU_W   = CNT_W + 1,
  localparam int SEQ_W  = $clog2(MAX_LINES),
  localparam int NL_W   = $clog2(MAX_LINES + 1),
  localparam int LINE_W = SLOTS * UOP_W,
  localparam int EV_W   = VA_W - OFF_W - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fill_valid,
  input  logic              fill_first,
  input  logic              fill_last,
  input  logic [VA_W-1:0]   fill_addr,
  input  logic [OFF_W:0]    fill_next_off,
  input  logic [NU_W-1:0]   fill_nuops,
  input  logic              fill_taken,
  input  logic [LINE_W-1:0] fill_uops,
  output logic              fill_reject,
  input  logic              lk_valid,
  input  logic [VA_W-1:0]   lk_addr,
  output logic              lk_hit,
  output logic [SLOTS-1:0]  lk_slot_vld,
  output logic [LINE_W-1:0] lk_uops,
  output logic [OFF_W:0]    lk_next_off,
  output logic              lk_taken,
  output logic [SEQ_W-1:0]  lk_seq,
  input  logic              inv_all,
  input  logic              evict_valid,
  input  logic [EV_W-1:0]   evict_line
);

  logic              v      [SETS][WAYS];
  logic [TAG_W-1:0]  tag_q  [SETS][WAYS];
  logic [OFF_W-1:0]  soff_q [SETS][WAYS];
  logic [SEQ_W-1:0]  seq_q  [SETS][WAYS];
  logic [OFF_W:0]    nxt_q  [SETS][WAYS];
  logic              tk_q   [SETS][WAYS];
  logic [CNT_W-1:0]  cnt_q  [SETS][WAYS];
  logic [LINE_W-1:0] dat_q  [SETS][WAYS];
  logic [WAY_W-1:0]  rr     [SETS];

  logic [SET_W-1:0]  w_set;
  logic [TAG_W-1:0]  w_tag;
  logic              w_bad, w_open;
  logic [CNT_W-1:0]  w_cnt;
  logic [LINE_W-1:0] w_buf;
  logic [OFF_W-1:0]  w_soff;
  logic [SEQ_W-1:0]  w_seq;
  logic [OFF_W:0]    w_nxt;
  logic [NL_W-1:0]   w_nl, w_recn;
  logic [WAY_W-1:0]  rec_way [2**NL_W];

  wire [SET_W-1:0] cur_set  = fill_first ? fill_addr[OFF_W +: SET_W] : w_set;
  wire [TAG_W-1:0] cur_tag  = fill_first ? fill_addr[VA_W-1 -: TAG_W] : w_tag;
  wire             cur_bad  = fill_first ? 1'b0 : w_bad;
  wire             cur_open = fill_first ? 1'b0 : w_open;
  wire [CNT_W-1:0] cur_cnt  = fill_first ? '0 : w_cnt;
  wire [NL_W-1:0]  cur_nl   = fill_first ? '0 : w_nl;
  wire [NL_W-1:0]  cur_recn = fill_first ? '0 : w_recn;
  wire [OFF_W-1:0] in_off   = fill_addr[OFF_W-1:0];

  wire [NU_W:0] sum      = (NU_W+1)'(cur_cnt) + (NU_W+1)'(fill_nuops);
  wire          fits     = cur_open && (sum <= (NU_W+1)'(SLOTS));
  wire          need_new = !fits;
  wire          too_big  = fill_nuops > NU_W'(SLOTS);
  wire          overflow = need_new && (cur_nl == NL_W'(MAX_LINES));
  wire          act      = fill_valid && !cur_bad;
  wire          rej      = act && (too_big || overflow);
  wire          good     = act && !rej;
  wire          wr_old   = good && need_new && cur_open;

  wire [CNT_W-1:0] base_cnt = fits ? cur_cnt : '0;
  wire [CNT_W-1:0] new_cnt  = fits ? sum[CNT_W-1:0] : fill_nuops[CNT_W-1:0];
  wire             close_new = good && (fill_taken || fill_last || new_cnt == CNT_W'(SLOTS));
  wire [OFF_W-1:0] new_soff = fits ? w_soff : in_off;
  wire [SEQ_W-1:0] new_seq  = fits ? w_seq : SEQ_W'(cur_nl);
  wire [NL_W-1:0]  new_nl   = need_new ? cur_nl + 1'b1 : cur_nl;
  wire [WAY_W-1:0] way_a    = rr[cur_set];
  wire [WAY_W-1:0] way_b    = way_a + WAY_W'(wr_old);

  logic [LINE_W-1:0] lmask, merged;
  always_comb begin
    for (int s = 0; s < SLOTS; s++)
      lmask[s*UOP_W +: UOP_W] = (s < int'(fill_nuops)) ? '1 : '0;
    merged = (fits ? w_buf : '0) | ((fill_uops & lmask) << (int'(base_cnt) * UOP_W));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fill_reject <= 1'b0;
      w_set <= '0; w_tag <= '0; w_bad <= 1'b0; w_open <= 1'b0; w_cnt <= '0;
      w_buf <= '0; w_soff <= '0; w_seq <= '0; w_nxt <= '0; w_nl <= '0; w_recn <= '0;
      for (int s = 0; s < SETS; s++) rr[s] <= '0;
      for (int r = 0; r < 2**NL_W; r++) rec_way[r] <= '0;
    end else begin
      fill_reject <= rej;
      if (fill_valid) begin
        w_set <= cur_set;
        w_tag <= cur_tag;
        w_bad <= cur_bad | rej;
        if (good) begin
          w_open <= !close_new;
          w_cnt  <= new_cnt;
          w_buf  <= merged;
          w_soff <= new_soff;
          w_seq  <= new_seq;
          w_nxt  <= fill_next_off;
          w_nl   <= new_nl;
          w_recn <= cur_recn + NL_W'(wr_old) + NL_W'(close_new);
          rr[cur_set] <= rr[cur_set] + WAY_W'(wr_old) + WAY_W'(close_new);
          if (wr_old) rec_way[cur_recn] <= way_a;
          if (close_new) rec_way[cur_recn + NL_W'(wr_old)] <= way_b;
        end else begin
          w_open <= 1'b0;
          w_cnt  <= cur_cnt;
          w_nl   <= cur_nl;
          w_recn <= cur_recn;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wr_old) begin
      tag_q[cur_set][way_a]  <= cur_tag;
      soff_q[cur_set][way_a] <= w_soff;
      seq_q[cur_set][way_a]  <= w_seq;
      nxt_q[cur_set][way_a]  <= w_nxt;
      tk_q[cur_set][way_a]   <= 1'b0;
      cnt_q[cur_set][way_a]  <= w_cnt;
      dat_q[cur_set][way_a]  <= w_buf;
    end
    if (close_new) begin
      tag_q[cur_set][way_b]  <= cur_tag;
      soff_q[cur_set][way_b] <= new_soff;
      seq_q[cur_set][way_b]  <= new_seq;
      nxt_q[cur_set][way_b]  <= fill_next_off;
      tk_q[cur_set][way_b]   <= fill_taken;
      cnt_q[cur_set][way_b]  <= new_cnt;
      dat_q[cur_set][way_b]  <= merged;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++) v[s][w] <= 1'b0;
    end else begin
      if (wr_old) v[cur_set][way_a] <= 1'b1;
      if (close_new) v[cur_set][way_b] <= 1'b1;
      if (rej)
        for (int r = 0; r < MAX_LINES; r++)
          if (r < int'(cur_recn)) v[cur_set][rec_way[r]] <= 1'b0;
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++)
          if (inv_all || (evict_valid && (SET_W-1)'(s >> 1) == evict_line[SET_W-2:0] &&
                          tag_q[s][w] == evict_line[EV_W-1 -: TAG_W]))
            v[s][w] <= 1'b0;
    end
  end

  wire [SET_W-1:0] lk_set = lk_addr[OFF_W +: SET_W];
  wire [TAG_W-1:0] lk_tag = lk_addr[VA_W-1 -: TAG_W];
  wire [OFF_W-1:0] lk_off = lk_addr[OFF_W-1:0];

  logic             m_hit;
  logic [WAY_W-1:0] m_way;
  logic [SLOTS-1:0] m_vld;
  always_comb begin
    m_hit = 1'b0;
    m_way = '0;
    for (int w = WAYS - 1; w >= 0; w--)
      if (v[lk_set][w] && tag_q[lk_set][w] == lk_tag && soff_q[lk_set][w] == lk_off) begin
        m_hit = 1'b1;
        m_way = WAY_W'(w);
      end
    for (int s = 0; s < SLOTS; s++)
      m_vld[s] = s < int'(cnt_q[lk_set][m_way]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lk_hit <= 1'b0; lk_slot_vld <= '0; lk_uops <= '0;
      lk_next_off <= '0; lk_taken <= 1'b0; lk_seq <= '0;
    end else begin
      lk_hit      <= lk_valid && m_hit;
      lk_slot_vld <= m_vld;
      lk_uops     <= dat_q[lk_set][m_way];
      lk_next_off <= nxt_q[lk_set][m_way];
      lk_taken    <= tk_q[lk_set][m_way];
      lk_seq      <= seq_q[lk_set][m_way];
    end
  end

endmodule

// File: rtl/uop_line_packer_chk.sv
module uop_line_packer_chk #(
  parameter int SLOTS     = 6,
  parameter int MAX_LINES = 3,
  localparam int CNT_W = $clog2(SLOTS + 1),
  localparam int NU_W  = CNT_W + 1,
  localparam int SEQ_W = $clog2(MAX_LINES)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             fill_valid,
  input logic [NU_W-1:0]  fill_nuops,
  input logic             fill_reject,
  input logic             lk_valid,
  input logic             lk_hit,
  input logic [SLOTS-1:0] lk_slot_vld,
  input logic [SEQ_W-1:0] lk_seq,
  input logic             inv_all
);

  p_hit_needs_lookup_r1: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> $past(lk_valid));

  p_slots_prefix_r2: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> (lk_slot_vld[0] && ((lk_slot_vld & (lk_slot_vld + 1'b1)) == '0)));

  p_nuops_nonzero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid |-> (fill_nuops != '0));

  p_seq_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> (int'(lk_seq) < MAX_LINES));

  p_reject_from_fill_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fill_reject |-> $past(fill_valid));

  p_flush_misses_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(inv_all) && lk_valid) |=> !lk_hit);

endmodule

bind uop_line_packer uop_line_packer_chk #(.SLOTS(SLOTS), .MAX_LINES(MAX_LINES)) u_chk (
  .clk(clk), .rst_n(rst_n), .fill_valid(fill_valid), .fill_nuops(fill_nuops),
  .fill_reject(fill_reject), .lk_valid(lk_valid), .lk_hit(lk_hit),
  .lk_slot_vld(lk_slot_vld), .lk_seq(lk_seq), .inv_all(inv_all)
);

// File: tb/tb_uop_line_packer.sv
`timescale 1ns/1ps
module tb_uop_line_packer;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        fill_valid = 0, fill_first = 0, fill_last = 0, fill_taken = 0;
  logic [31:0] fill_addr = '0;
  logic [5:0]  fill_next_off = '0;
  logic [3:0]  fill_nuops = '0;
  logic [95:0] fill_uops = '0;
  logic        fill_reject;
  logic        lk_valid = 0;
  logic [31:0] lk_addr = '0;
  logic        lk_hit, lk_taken;
  logic [5:0]  lk_slot_vld, lk_next_off;
  logic [95:0] lk_uops;
  logic [1:0]  lk_seq;
  logic        inv_all = 0, evict_valid = 0;
  logic [25:0] evict_line = '0;

  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  uop_line_packer dut (
    .clk(clk), .rst_n(rst_n), .fill_valid(fill_valid), .fill_first(fill_first),
    .fill_last(fill_last), .fill_addr(fill_addr), .fill_next_off(fill_next_off),
    .fill_nuops(fill_nuops), .fill_taken(fill_taken), .fill_uops(fill_uops),
    .fill_reject(fill_reject), .lk_valid(lk_valid), .lk_addr(lk_addr), .lk_hit(lk_hit),
    .lk_slot_vld(lk_slot_vld), .lk_uops(lk_uops), .lk_next_off(lk_next_off),
    .lk_taken(lk_taken), .lk_seq(lk_seq), .inv_all(inv_all),
    .evict_valid(evict_valid), .evict_line(evict_line)
  );

  typedef struct packed {
    logic [31:0] a;
    logic        h;
    logic [5:0]  sv;
    logic [5:0]  nx;
    logic        tk;
    logic [1:0]  sq;
    logic [15:0] u0;
    logic [15:0] ul;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t TBL [NV] = '{
    '{32'h1240, 1'b1, 6'h1F, 6'd7,  1'b0, 2'd0, 16'h0100, 16'h0202},
    '{32'h1247, 1'b1, 6'h07, 6'd14, 1'b1, 2'd1, 16'h0300, 16'h0400},
    '{32'h124E, 1'b1, 6'h0F, 6'd20, 1'b0, 2'd2, 16'h0500, 16'h0503},
    '{32'h1243, 1'b0, 6'h00, 6'd0,  1'b0, 2'd0, 16'h0000, 16'h0000},
    '{32'h2060, 1'b0, 6'h00, 6'd0,  1'b0, 2'd0, 16'h0000, 16'h0000},
    '{32'h2064, 1'b0, 6'h00, 6'd0,  1'b0, 2'd0, 16'h0000, 16'h0000},
    '{32'h2068, 1'b0, 6'h00, 6'd0,  1'b0, 2'd0, 16'h0000, 16'h0000},
    '{32'h3000, 1'b0, 6'h00, 6'd0,  1'b0, 2'd0, 16'h0000, 16'h0000},
    '{32'h3009, 1'b0, 6'h00, 6'd0,  1'b0, 2'd0, 16'h0000, 16'h0000},
    '{32'h4100, 1'b1, 6'h3F, 6'd5,  1'b0, 2'd0, 16'h3000, 16'h3101},
    '{32'h4105, 1'b1, 6'h01, 6'd8,  1'b0, 2'd1, 16'h3200, 16'h3200},
    '{32'h4140, 1'b1, 6'h1F, 6'd4,  1'b0, 2'd0, 16'h4000, 16'h4004},
    '{32'h4144, 1'b1, 6'h07, 6'd9,  1'b1, 2'd1, 16'h4100, 16'h4102},
    '{32'h1260, 1'b1, 6'h01, 6'd2,  1'b0, 2'd0, 16'h5000, 16'h5000},
    '{32'h1280, 1'b1, 6'h01, 6'd2,  1'b0, 2'd0, 16'h5100, 16'h5100},
    '{32'h20A0, 1'b0, 6'h00, 6'd0,  1'b0, 2'd0, 16'h0000, 16'h0000},
    '{32'h40A0, 1'b1, 6'h01, 6'd1,  1'b0, 2'd0, 16'h6200, 16'h6200},
    '{32'h120A0,1'b1, 6'h01, 6'd1,  1'b0, 2'd0, 16'h6900, 16'h6900}
  };

  function automatic string tag_of(int i);
    if (i <= 3)  return "R2";
    if (i <= 6)  return "R4";
    if (i <= 8)  return "R5";
    if (i <= 12) return "R3";
    if (i <= 14) return "R1";
    return "R6";
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic send(input logic first, input logic last, input logic [31:0] addr,
                      input int nxt, input int nu, input logic tk, input logic [7:0] id);
    fill_valid = 1; fill_first = first; fill_last = last; fill_addr = addr;
    fill_next_off = 6'(nxt); fill_nuops = 4'(nu); fill_taken = tk;
    fill_uops = '0;
    for (int k = 0; k < 6; k++)
      if (k < nu) fill_uops[k*16 +: 16] = {id, 8'(k)};
    @(posedge clk);
    @(negedge clk);
    fill_valid = 0; fill_first = 0; fill_last = 0; fill_taken = 0;
  endtask

  task automatic lookup(input logic [31:0] addr);
    lk_valid = 1; lk_addr = addr;
    @(posedge clk);
    @(negedge clk);
    lk_valid = 0;
  endtask

  task automatic finish_up();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R9: empty after reset
    lookup(32'h1240);
    chk(lk_hit == 1'b0, "R9", "hit after reset", 64'(lk_hit), 64'd0);
    chk(fill_reject == 1'b0, "R9", "reject after reset", 64'(fill_reject), 64'd0);

    // window packed over three lines: fit rule and branch close
    send(1, 0, 32'h1240, 3,  2, 0, 8'h01);
    send(0, 0, 32'h1243, 7,  3, 0, 8'h02);
    send(0, 0, 32'h1247, 10, 2, 0, 8'h03);
    send(0, 0, 32'h124A, 14, 1, 1, 8'h04);
    send(0, 1, 32'h124E, 20, 4, 0, 8'h05);

    // R4: fourth line rejects window
    send(1, 0, 32'h2060, 4,  6, 0, 8'h10);
    send(0, 0, 32'h2064, 8,  6, 0, 8'h11);
    send(0, 0, 32'h2068, 12, 6, 0, 8'h12);
    send(0, 1, 32'h206C, 13, 1, 0, 8'h13);
    chk(fill_reject == 1'b1, "R4", "reject pulse", 64'(fill_reject), 64'd1);
    @(negedge clk);
    chk(fill_reject == 1'b0, "R4", "reject one cycle", 64'(fill_reject), 64'd0);

    // R5: oversize instruction rejects window, later ones ignored
    send(1, 0, 32'h3000, 2, 2, 0, 8'h20);
    send(0, 0, 32'h3002, 9, 7, 0, 8'h21);
    chk(fill_reject == 1'b1, "R5", "oversize reject", 64'(fill_reject), 64'd1);
    send(0, 1, 32'h3009, 10, 1, 0, 8'h22);
    chk(fill_reject == 1'b0, "R5", "no second pulse", 64'(fill_reject), 64'd0);

    // R3: close on full line
    send(1, 0, 32'h4100, 3, 4, 0, 8'h30);
    send(0, 0, 32'h4103, 5, 2, 0, 8'h31);
    send(0, 1, 32'h4105, 8, 1, 0, 8'h32);
    // R2/R3: old line written while new line closes on branch
    send(1, 0, 32'h4140, 4, 5, 0, 8'h40);
    send(0, 1, 32'h4144, 9, 3, 1, 8'h41);

    send(1, 1, 32'h1260, 2, 1, 0, 8'h50);
    send(1, 1, 32'h1280, 2, 1, 0, 8'h51);

    // R6: nine windows into one set
    for (int k = 1; k <= 9; k++)
      send(1, 1, 32'(k * 32'h2000 + 32'hA0), 1, 1, 0, 8'(8'h60 + k));

    for (int i = 0; i < NV; i++) begin
      automatic int li;
      automatic bit ok;
      lookup(TBL[i].a);
      li = $countones(TBL[i].sv) - 1;
      if (li < 0) li = 0;
      ok = (lk_hit == TBL[i].h);
      if (TBL[i].h)
        ok = ok && lk_slot_vld == TBL[i].sv && lk_next_off == TBL[i].nx &&
             lk_taken == TBL[i].tk && lk_seq == TBL[i].sq &&
             lk_uops[15:0] == TBL[i].u0 && lk_uops[li*16 +: 16] == TBL[i].ul;
      chk(ok, tag_of(i), $sformatf("lookup %h", TBL[i].a),
          {lk_hit, lk_slot_vld, lk_next_off, lk_taken, lk_seq, lk_uops[15:0], lk_uops[li*16 +: 16]},
          {TBL[i].h, TBL[i].sv, TBL[i].nx, TBL[i].tk, TBL[i].sq, TBL[i].u0, TBL[i].ul});
    end

    // R8: 64-byte eviction covering 0x1240..0x127F
    evict_valid = 1; evict_line = 26'(32'h1250 >> 6);
    @(posedge clk); @(negedge clk);
    evict_valid = 0;
    lookup(32'h1240); chk(lk_hit == 1'b0, "R8", "lower window evicted", 64'(lk_hit), 64'd0);
    lookup(32'h1247); chk(lk_hit == 1'b0, "R8", "lower window line1", 64'(lk_hit), 64'd0);
    lookup(32'h1260); chk(lk_hit == 1'b0, "R8", "upper window evicted", 64'(lk_hit), 64'd0);
    lookup(32'h1280); chk(lk_hit == 1'b1, "R8", "neighbour kept", 64'(lk_hit), 64'd1);

    // R7: full flush
    inv_all = 1;
    @(posedge clk); @(negedge clk);
    inv_all = 0;
    lookup(32'h4100);  chk(lk_hit == 1'b0, "R7", "flush 4100", 64'(lk_hit), 64'd0);
    lookup(32'h40A0);  chk(lk_hit == 1'b0, "R7", "flush 40A0", 64'(lk_hit), 64'd0);
    lookup(32'h1280);  chk(lk_hit == 1'b0, "R7", "flush 1280", 64'(lk_hit), 64'd0);

    finish_up();
  end
endmodule